// File: doc/BRIEF.md
# Instruction Fetch Buffer Filler

This block models the front end that moves instructions into an instruction buffer each clock. It keeps a word-aligned fetch address. It reports how many consecutive 32-bit instructions enter the buffer in the current cycle and the address of the first one. The count is limited by where the address sits inside its aligned 32-byte block of eight instructions. The block also tracks the gaps that come from prediction failures and instruction-cache misses. An instruction-cache miss either hits the second-level cache and refills after a short fixed delay, or misses there too and waits for a first-word indication from a lower-level stub before a longer fixed delay.

The surrounding logic supplies the hit and prediction status for the current fetch address, a buffer-full stall and a redirect to a new address. The count and address outputs are valid in the same cycle as those inputs. Two configuration inputs choose between the two permitted lengths of the miss delay and of the gap after a refill, so that either value can be used deterministically.

Top module: `ifill_fetch`

## Requirements
- R1: In a cycle that delivers, the count is min(4, 8 - w), where w is the word offset (address bits [4:2]) of `add_pc`. Byte offsets 0 to 16 within the 32-byte block give 4, and offsets 20, 24 and 28 give 3, 2 and 1. The instructions delivered are those at `add_pc`, `add_pc`+4, and so on.
- R2: After a cycle that delivers N instructions, `add_pc` has advanced by 4*N on the next cycle. It does not change in cycles that deliver nothing, except on redirect or reset.
- R3: While `buf_full` is high, the count is 0 and the fetch address is held, so no instruction is lost or skipped.
- R4: When `mispred` is high in a fetch cycle, with no stall and no redirect, nothing is delivered in that cycle or the next one. Fetch then resumes at the same address.
- R5: When `ic_hit` is low in a fetch cycle and `l2_hit` is high, `l2_req` pulses for that cycle. The first refill delivery comes 5 cycles after the miss cycle when `miss_lat_long` is 0, and 6 cycles after when it is 1.
- R6: A refill delivers the instructions from the miss address to the end of its 32-byte block, which is up to eight. They come over one or two cycles, with the per-cycle limit of R1, and a refill cycle with `buf_full` high delivers nothing and keeps its place.
- R7: After the last refill delivery, nothing is delivered for 1 cycle when `post_bub_long` is 0, or 2 cycles when it is 1, before fetch resumes. With the short settings, two misses on an aligned address in a row are 8 cycles apart.
- R8: When an instruction-cache miss also misses the second-level cache (`l2_hit` low), the block waits for `fill_first_vld`. The first refill delivery then comes 11 cycles after the cycle in which `fill_first_vld` is seen.
- R9: A cycle with `redirect_vld` high delivers nothing, whatever the current phase. On the next cycle fetch runs at `redirect_pc` with bits [1:0] cleared.
- R10: While waiting for a miss, `ic_hit`, `mispred` and `buf_full` have no effect, and the count stays 0.
- R11: After reset the fetch address is `RESET_ADDR` (0), the block is in the fetch phase, and `l2_req` is low unless a miss is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect_vld | input | 1 | Flush and restart at `redirect_pc` |
| redirect_pc | input | AW | New fetch address |
| mispred | input | 1 | Next-line or set prediction failed for this fetch |
| ic_hit | input | 1 | Instruction cache hit for the current fetch address |
| l2_hit | input | 1 | Second-level cache hit for a miss presented this cycle |
| fill_first_vld | input | 1 | First word of a second-level-miss fill has arrived |
| buf_full | input | 1 | Instruction buffer cannot accept this cycle |
| miss_lat_long | input | 1 | 0: 5-cycle, 1: 6-cycle second-level hit delay |
| post_bub_long | input | 1 | 0: 1-cycle, 1: 2-cycle gap after refill |
| add_cnt | output | 3 | Instructions entering the buffer this cycle |
| add_pc | output | AW | Address of the first instruction counted in `add_cnt` |
| l2_req | output | 1 | Miss request to the lower level, one cycle |

## Verification
The bench visits every fetch position within the 32-byte block, including the three short positions. A limiter that got these wrong would over-fill near the end of a block or skip the instructions at its start. It times the miss delay, the second-level-miss delay and both lengths of the post-refill gap cycle by cycle, so a counter that is off by one shows up as a delivery one cycle early or late. Stalls are placed inside a refill and a redirect is placed inside a miss wait, which exposes a refill that loses its place or a redirect that leaves the block stuck waiting. A final reset in the middle of a miss must return the block to fetching at address zero.

// File: rtl/ifill_pkg.sv
package ifill_pkg;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_BUB,
    ST_XWAIT,
    ST_MWAIT,
    ST_REFILL,
    ST_POST
  } ifill_state_e;

  // Instructions that can be taken from word offset word_off before the
  // end of the aligned block, capped by the fetch width.
  function automatic int unsigned lanes_avail(input int unsigned word_off,
                                              input int unsigned fetch_w,
                                              input int unsigned blk_w);
    int unsigned left;
    left = blk_w - word_off;
    return (left < fetch_w) ? left : fetch_w;
  endfunction

endpackage

// File: rtl/ifill_align.sv
module ifill_align #(
  parameter int AW      = 32,
  parameter int FETCH_W = 4,
  parameter int BLK_W   = 8
) (
  input  logic [AW-1:0]                    addr,
  output logic [$clog2(FETCH_W+1)-1:0]     avail,
  output logic [AW-1:0]                    addr_adv,
  output logic                             blk_end
);
  import ifill_pkg::*;

  localparam int CNTW = $clog2(FETCH_W + 1);
  localparam int OFFW = $clog2(BLK_W);

  logic [OFFW-1:0] word_off;
  logic [31:0]     off_ext;
  logic [31:0]     lanes;

  assign word_off = addr[OFFW+1:2];
  assign off_ext  = {{(32-OFFW){1'b0}}, word_off};
  assign lanes    = lanes_avail(off_ext, FETCH_W, BLK_W);
  assign avail    = lanes[CNTW-1:0];
  assign addr_adv = addr + (AW'(avail) << 2);
  assign blk_end  = (off_ext + lanes) == 32'(BLK_W);

endmodule

// File: rtl/ifill_timer.sv
module ifill_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // Last cycle of a window of load_val cycles.
  assign expire = (cnt_q == CW'(1));

endmodule

// File: rtl/ifill_fetch.sv
module ifill_fetch #(
  parameter int          AW             = 32,
  parameter int          FETCH_W        = 4,
  parameter int          BLK_W          = 8,
  parameter int          MISS_LAT_SHORT = 5,
  parameter int          MISS_LAT_LONG  = 6,
  parameter int          POST_BUB_SHORT = 1,
  parameter int          POST_BUB_LONG  = 2,
  parameter int          MISPRED_BUB    = 2,
  parameter int          L2_MISS_EXTRA  = 11,
  parameter logic [31:0] RESET_ADDR     = 32'h0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          redirect_vld,
  input  logic [AW-1:0]                 redirect_pc,
  input  logic                          mispred,
  input  logic                          ic_hit,
  input  logic                          l2_hit,
  input  logic                          fill_first_vld,
  input  logic                          buf_full,
  input  logic                          miss_lat_long,
  input  logic                          post_bub_long,
  output logic [$clog2(FETCH_W+1)-1:0]  add_cnt,
  output logic [AW-1:0]                 add_pc,
  output logic                          l2_req
);
  import ifill_pkg::*;

  localparam int CNTW = $clog2(FETCH_W + 1);
  // Every delay window must be at least one cycle after its trigger cycle,
  // so all loaded values are >= 1 and fit in CW bits.
  localparam int CW   = $clog2(L2_MISS_EXTRA + MISS_LAT_LONG + POST_BUB_LONG + MISPRED_BUB + 1);

  ifill_state_e  state_q, state_d;
  logic [AW-1:0] pc_q, pc_d;

  logic [CNTW-1:0] avail;
  logic [AW-1:0]   pc_adv;
  logic            blk_end;

  // Named internal events, brought out for the checker.
  logic can_take;
  logic ev_mispred;
  logic ev_miss;
  logic ev_hit_grant;
  logic ev_refill_beat;
  logic ev_refill_done;
  logic ev_fill_first;
  logic ev_deliver;

  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_expire;

  ifill_align #(
    .AW      (AW),
    .FETCH_W (FETCH_W),
    .BLK_W   (BLK_W)
  ) u_align (
    .addr     (pc_q),
    .avail    (avail),
    .addr_adv (pc_adv),
    .blk_end  (blk_end)
  );

  ifill_timer #(
    .CW (CW)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expire   (tmr_expire)
  );

  assign can_take       = !redirect_vld && !buf_full;
  assign ev_mispred     = (state_q == ST_FETCH) && can_take && mispred;
  assign ev_miss        = (state_q == ST_FETCH) && can_take && !mispred && !ic_hit;
  assign ev_hit_grant   = (state_q == ST_FETCH) && can_take && !mispred && ic_hit;
  assign ev_refill_beat = (state_q == ST_REFILL) && can_take;
  assign ev_refill_done = ev_refill_beat && blk_end;
  assign ev_fill_first  = (state_q == ST_XWAIT) && fill_first_vld && !redirect_vld;
  assign ev_deliver     = ev_hit_grant || ev_refill_beat;

  assign add_cnt = ev_deliver ? avail : '0;
  assign add_pc  = pc_q;
  assign l2_req  = ev_miss;

  // One timer serves every fixed-length gap; only one can be open at a time.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (ev_mispred) begin
      tmr_load = 1'b1;
      tmr_val  = CW'(MISPRED_BUB - 1);
    end else if (ev_miss && l2_hit) begin
      tmr_load = 1'b1;
      tmr_val  = miss_lat_long ? CW'(MISS_LAT_LONG - 1) : CW'(MISS_LAT_SHORT - 1);
    end else if (ev_fill_first) begin
      tmr_load = 1'b1;
      tmr_val  = CW'(L2_MISS_EXTRA - 1);
    end else if (ev_refill_done) begin
      tmr_load = 1'b1;
      tmr_val  = post_bub_long ? CW'(POST_BUB_LONG) : CW'(POST_BUB_SHORT);
    end
  end

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    if (redirect_vld) begin
      state_d = ST_FETCH;
      pc_d    = redirect_pc & ~AW'(3);
    end else begin
      case (state_q)
        ST_FETCH: begin
          if (ev_mispred) begin
            state_d = ST_BUB;
          end else if (ev_miss) begin
            state_d = l2_hit ? ST_MWAIT : ST_XWAIT;
          end else if (ev_hit_grant) begin
            pc_d = pc_adv;
          end
        end
        ST_BUB, ST_POST: begin
          if (tmr_expire) state_d = ST_FETCH;
        end
        ST_XWAIT: begin
          if (fill_first_vld) state_d = ST_MWAIT;
        end
        ST_MWAIT: begin
          if (tmr_expire) state_d = ST_REFILL;
        end
        ST_REFILL: begin
          if (ev_refill_beat) pc_d = pc_adv;
          if (ev_refill_done) state_d = ST_POST;
        end
        default: state_d = ST_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      pc_q    <= AW'(RESET_ADDR);
    end else begin
      state_q <= state_d;
      pc_q    <= pc_d;
    end
  end

endmodule

// File: rtl/ifill_fetch_chk.sv
module ifill_fetch_chk #(
  parameter int AW      = 32,
  parameter int FETCH_W = 4,
  parameter int BLK_W   = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          redirect_vld,
  input logic [AW-1:0]                 redirect_pc,
  input logic                          buf_full,
  input logic [$clog2(FETCH_W+1)-1:0]  add_cnt,
  input logic [AW-1:0]                 add_pc,
  input logic                          l2_req,
  input logic                          ev_mispred,
  input logic                          ev_fill_first
);
  localparam int OFFW = $clog2(BLK_W);

  logic [31:0] off_ext;
  logic [31:0] cnt_ext;
  assign off_ext = {{(32-OFFW){1'b0}}, add_pc[OFFW+1:2]};
  assign cnt_ext = 32'(add_cnt);

  AST_LANE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_ext <= 32'(FETCH_W)) && (off_ext + cnt_ext <= 32'(BLK_W))); // R1

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (add_cnt != '0) |=> add_pc == $past(add_pc) + (AW'($past(add_cnt)) << 2)); // R2

  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full |-> add_cnt == '0); // R3

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && !redirect_vld) |=> add_pc == $past(add_pc)); // R3

  AST_MISPRED_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mispred |=> add_cnt == '0); // R4

  AST_MISS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    l2_req |=> (add_cnt == '0) && !l2_req); // R5

  AST_FILL_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill_first |=> add_cnt == '0); // R8

  AST_REDIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_vld |-> (add_cnt == '0) && !l2_req); // R9

  AST_REDIR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_vld |=> add_pc == ($past(redirect_pc) & ~AW'(3))); // R9

endmodule

bind ifill_fetch ifill_fetch_chk #(
  .AW      (AW),
  .FETCH_W (FETCH_W),
  .BLK_W   (BLK_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .redirect_vld  (redirect_vld),
  .redirect_pc   (redirect_pc),
  .buf_full      (buf_full),
  .add_cnt       (add_cnt),
  .add_pc        (add_pc),
  .l2_req        (l2_req),
  .ev_mispred    (ev_mispred),
  .ev_fill_first (ev_fill_first)
);

// File: tb/test_ifill_fetch.sv
module test_ifill_fetch;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        redirect_vld;
  logic [31:0] redirect_pc;
  logic        mispred, ic_hit, l2_hit, fill_first_vld, buf_full;
  logic        miss_lat_long, post_bub_long;
  logic [2:0]  add_cnt;
  logic [31:0] add_pc;
  logic        l2_req;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk; // 125 MHz

  ifill_fetch i_ifill_fetch (
    .clk            (clk),
    .rst_n          (rst_n),
    .redirect_vld   (redirect_vld),
    .redirect_pc    (redirect_pc),
    .mispred        (mispred),
    .ic_hit         (ic_hit),
    .l2_hit         (l2_hit),
    .fill_first_vld (fill_first_vld),
    .buf_full       (buf_full),
    .miss_lat_long  (miss_lat_long),
    .post_bub_long  (post_bub_long),
    .add_cnt        (add_cnt),
    .add_pc         (add_pc),
    .l2_req         (l2_req)
  );

  // Row: {rd, mp, hit, l2h, fwv, full, mlong, plong}, redirect addr, count, first addr
  localparam int NV = 63;
  localparam logic [42:0] VEC [NV] = '{
    {8'b10100000, 16'h0104, 3'd0, 16'h0000},  // 0
    {8'b00100000, 16'h0000, 3'd4, 16'h0104},
    {8'b00100000, 16'h0000, 3'd3, 16'h0114},
    {8'b00100000, 16'h0000, 3'd4, 16'h0120},
    {8'b00100000, 16'h0000, 3'd4, 16'h0130},
    {8'b10100000, 16'h0158, 3'd0, 16'h0140},  // 5
    {8'b00100000, 16'h0000, 3'd2, 16'h0158},
    {8'b10100000, 16'h017C, 3'd0, 16'h0160},
    {8'b00100000, 16'h0000, 3'd1, 16'h017C},
    {8'b00100100, 16'h0000, 3'd0, 16'h0180},  // 9 stall
    {8'b00100100, 16'h0000, 3'd0, 16'h0180},
    {8'b00100000, 16'h0000, 3'd4, 16'h0180},
    {8'b01100000, 16'h0000, 3'd0, 16'h0190},  // 12 mispredict
    {8'b00100000, 16'h0000, 3'd0, 16'h0190},
    {8'b00100000, 16'h0000, 3'd4, 16'h0190},
    {8'b00010000, 16'h0000, 3'd0, 16'h01A0},  // 15 miss, L2 hit, short
    {8'b00100000, 16'h0000, 3'd0, 16'h01A0},
    {8'b01100100, 16'h0000, 3'd0, 16'h01A0},
    {8'b00100000, 16'h0000, 3'd0, 16'h01A0},
    {8'b00100000, 16'h0000, 3'd0, 16'h01A0},
    {8'b00100000, 16'h0000, 3'd4, 16'h01A0},  // 20 refill
    {8'b00100000, 16'h0000, 3'd4, 16'h01B0},
    {8'b00100000, 16'h0000, 3'd0, 16'h01C0},  // 22 post gap 1
    {8'b00010010, 16'h0000, 3'd0, 16'h01C0},  // 23 miss, long
    {8'b00100000, 16'h0000, 3'd0, 16'h01C0},
    {8'b00100000, 16'h0000, 3'd0, 16'h01C0},
    {8'b00100000, 16'h0000, 3'd0, 16'h01C0},
    {8'b00100000, 16'h0000, 3'd0, 16'h01C0},
    {8'b00100000, 16'h0000, 3'd0, 16'h01C0},
    {8'b00100000, 16'h0000, 3'd4, 16'h01C0},  // 29 refill
    {8'b00100100, 16'h0000, 3'd0, 16'h01D0},  // 30 stall in refill
    {8'b00100001, 16'h0000, 3'd4, 16'h01D0},
    {8'b00100000, 16'h0000, 3'd0, 16'h01E0},  // 32 post gap 2
    {8'b00100000, 16'h0000, 3'd0, 16'h01E0},
    {8'b00100000, 16'h0000, 3'd4, 16'h01E0},
    {8'b00000000, 16'h0000, 3'd0, 16'h01F0},  // 35 miss, L2 miss
    {8'b00100000, 16'h0000, 3'd0, 16'h01F0},
    {8'b00100000, 16'h0000, 3'd0, 16'h01F0},
    {8'b00101000, 16'h0000, 3'd0, 16'h01F0},  // 38 first word
    {8'b00100000, 16'h0000, 3'd0, 16'h01F0},
    {8'b00100000, 16'h0000, 3'd0, 16'h01F0},
    {8'b00100000, 16'h0000, 3'd0, 16'h01F0},
    {8'b00100000, 16'h0000, 3'd0, 16'h01F0},
    {8'b00100000, 16'h0000, 3'd0, 16'h01F0},
    {8'b00100000, 16'h0000, 3'd0, 16'h01F0},
    {8'b00100000, 16'h0000, 3'd0, 16'h01F0},
    {8'b00100000, 16'h0000, 3'd0, 16'h01F0},
    {8'b00100000, 16'h0000, 3'd0, 16'h01F0},
    {8'b00100000, 16'h0000, 3'd0, 16'h01F0},
    {8'b00100000, 16'h0000, 3'd4, 16'h01F0},  // 49 refill
    {8'b00100000, 16'h0000, 3'd0, 16'h0200},
    {8'b00100000, 16'h0000, 3'd4, 16'h0200},
    {8'b00010000, 16'h0000, 3'd0, 16'h0210},  // 52 miss
    {8'b00100000, 16'h0000, 3'd0, 16'h0210},
    {8'b10100000, 16'h0234, 3'd0, 16'h0210},  // 54 redirect in wait
    {8'b00010000, 16'h0000, 3'd0, 16'h0234},  // 55 miss at offset 5
    {8'b00100000, 16'h0000, 3'd0, 16'h0234},
    {8'b00100000, 16'h0000, 3'd0, 16'h0234},
    {8'b00100000, 16'h0000, 3'd0, 16'h0234},
    {8'b00100000, 16'h0000, 3'd0, 16'h0234},
    {8'b00100000, 16'h0000, 3'd3, 16'h0234},  // 60 partial refill
    {8'b00100000, 16'h0000, 3'd0, 16'h0240},
    {8'b00100000, 16'h0000, 3'd4, 16'h0240}
  };

  function automatic string row_req(input int i);
    if (i <= 8)  return "R1";
    if (i <= 11) return "R3";
    if (i <= 14) return "R4";
    if (i == 15) return "R5";
    if (i <= 19) return "R10";
    if (i <= 21) return "R6";
    if (i <= 33) return "R7";
    if (i <= 51) return "R8";
    if (i <= 54) return "R9";
    return "R6";
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    redirect_vld = 1'b0; redirect_pc = '0; mispred = 1'b0; ic_hit = 1'b1;
    l2_hit = 1'b0; fill_first_vld = 1'b0; buf_full = 1'b0;
    miss_lat_long = 1'b0; post_bub_long = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle_inputs();
    buf_full = 1'b1;
    rst_n    = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R11", add_pc, 32'h0);
    chk("R11", {29'd0, add_cnt}, 32'd0);
    chk("R11", {31'd0, l2_req}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {redirect_vld, mispred, ic_hit, l2_hit, fill_first_vld, buf_full,
       miss_lat_long, post_bub_long} = VEC[i][42:35];
      redirect_pc = {16'h0, VEC[i][34:19]};
      #2;
      chk(row_req(i), {29'd0, add_cnt}, {29'd0, VEC[i][18:16]});
      chk("R2", add_pc, {16'h0, VEC[i][15:0]});
    end

    // Miss request pulse, then quiet while waiting (R5, R10)
    @(negedge clk);
    idle_inputs(); ic_hit = 1'b0; l2_hit = 1'b1;
    #2;
    chk("R5", {31'd0, l2_req}, 32'd1);
    chk("R5", add_pc, 32'h250);
    @(negedge clk);
    idle_inputs();
    #2;
    chk("R10", {31'd0, l2_req}, 32'd0);
    chk("R10", {29'd0, add_cnt}, 32'd0);

    // Redirect with low bits set (R9)
    @(negedge clk);
    redirect_vld = 1'b1; redirect_pc = 32'h0000_0307;
    #2;
    chk("R9", {29'd0, add_cnt}, 32'd0);
    @(negedge clk);
    idle_inputs();
    #2;
    chk("R9", add_pc, 32'h304);
    chk("R1", {29'd0, add_cnt}, 32'd4);

    // Miss then reset in the middle of the wait (R11)
    @(negedge clk);
    ic_hit = 1'b0; l2_hit = 1'b1;
    @(negedge clk);
    idle_inputs();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R11", add_pc, 32'h0);
    chk("R11", {29'd0, add_cnt}, 32'd4);
    chk("R11", {31'd0, l2_req}, 32'd0);
    @(negedge clk);
    #2;
    chk("R2", add_pc, 32'h10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule